// File: doc/BRIEF.md
# Disk Controller Host Command/Result Port

This block is the processor side of a disk controller's register interface. A host reaches two byte registers through one address line: a read-only status register (address 0) and a data register (address 1). Every access is qualified by an active-low chip select together with an active-low read or write strobe. An access takes effect on the first clock edge that samples its strobe released.

An internal phase machine steps through three phases. In the command phase it collects a multi-byte command. In the execution phase a stub executor presents data bytes. In the result phase the block hands back result bytes. Two status bits gate each command and result byte:

- The ready bit must be 1 before each transfer.
- The direction bit tells which way the next byte moves.

After every accepted data-register byte, the ready bit drops for a settling interval of `SETTLE_CYC` clock cycles. The host either waits that long or polls status. In the execution phase the status register does not gate transfers. Each data byte can raise an interrupt when the controller is set to the processor-driven (non-DMA) transfer mode. Any read strobe clears that interrupt.

The command decode and the executor are stand-ins that are only detailed enough to exercise the handshake. The first command byte `op` selects the lengths. The data output always shows the register that `addr_i` selects.

Top module: `fdc_host_port`

## Requirements
- R1: After reset, status reads 0x80 (ready=1, direction=0, busy=0) and `irq_o` is 0, whatever phase the block was in before.
- R2: Status register layout: bit 7 is ready, bit 6 is direction (1 = controller to host), bit 4 is busy, and all other bits are 0. Address 0 selects status and address 1 selects data. An access needs `cs_ni` low with `rd_ni` or `wr_ni` low.
- R3: A command is `op[1:0]+1` bytes long, and `op` is its first byte. At the clock edge that accepts the last byte, the block enters execution and status reads 0x10.
- R4: An accepted data-register byte in the command or result phase clears ready at the edge that ends the access. Ready returns exactly `SETTLE_CYC` cycles later.
- R5: A data write is ignored and does not advance the byte count in any of these cases: ready is 0, direction is 1, `cs_ni` is high, or the address is 0.
- R6: Execution presents `op[5:4]` data bytes. Byte k (from 0) is `op+k+1`, and each appears `EXEC_GAP` cycles after the previous event. The host reads these bytes from the data register without checking status. In non-DMA mode (`nondma_i`=1), each byte sets `irq_o`.
- R7: A read strobe with chip select to either address clears `irq_o` at the first clock edge that samples it.
- R8: With `nondma_i`=0, `irq_o` never rises.
- R9: The result phase begins `EXEC_GAP` cycles after the last execution byte is read, or after execution starts if there are no execution bytes. On entry, status reads 0xD0. The block then delivers `op[3:2]+1` result bytes, and byte k is `~op+k`.
- R10: After the last result byte is read, status reads 0x00. It reads 0x80 once the settling interval ends.
- R11: A result-phase data read while ready is 0 is ignored. The next valid read returns the byte that had not yet been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 1 | Register select: 0 status, 1 data |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Selected register contents |
| nondma_i | input | 1 | 1 = per-byte interrupt transfer mode |
| irq_o | output | 1 | Execution-byte interrupt |

## Verification
The hardest case to reach from the ports is a transfer attempted while the ready bit is low. It has to land inside the settling window, and a well-behaved host never does that. The bench therefore issues a second write, or a second result read, on the clock right after an accepted byte. It then shows that the count did not advance: the phase is unchanged, or the next byte read is the one not yet taken. The bench also times the return of the ready bit to the exact cycle. Each table entry picks a distinct mix of command, execution and result lengths and of transfer modes.

// File: rtl/fdc_hp_pkg.sv
package fdc_hp_pkg;
  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_EXE = 2'd1, PH_RES = 2'd2} phase_e;

  localparam int CNT_W = 3;

  function automatic logic [CNT_W-1:0] cmd_len(input logic [7:0] op);
    return {1'b0, op[1:0]} + 3'd1;
  endfunction

  function automatic logic [CNT_W-1:0] exe_cnt(input logic [7:0] op);
    return {1'b0, op[5:4]};
  endfunction

  function automatic logic [CNT_W-1:0] res_cnt(input logic [7:0] op);
    return {1'b0, op[3:2]} + 3'd1;
  endfunction
endpackage

// File: rtl/fdc_hp_strobe.sv
module fdc_hp_strobe (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic       addr_i,
  input  logic [7:0] data_i,
  output logic       rd_act_o,
  output logic       rd_end_o,
  output logic       wr_end_o,
  output logic       addr_o,
  output logic [7:0] wdat_o
);
  logic rd_now, wr_now, rd_q, wr_q;

  assign rd_now = ~cs_ni & ~rd_ni;
  assign wr_now = ~cs_ni & ~wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_o <= 1'b0;
      wdat_o <= '0;
    end else begin
      rd_q <= rd_now;
      wr_q <= wr_now;
      if (rd_now || wr_now) addr_o <= addr_i;
      if (wr_now) wdat_o <= data_i;
    end
  end

  assign rd_act_o = rd_now;
  // access takes effect on the edge where its strobe is seen released
  assign rd_end_o = rd_q & ~rd_now;
  assign wr_end_o = wr_q & ~wr_now;
endmodule

// File: rtl/fdc_hp_settle.sv
module fdc_hp_settle #(
  parameter int CYC = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int SW = $clog2(CYC + 1);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= SW'(CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == SW'(1));
endmodule

// File: rtl/fdc_hp_fsm.sv
module fdc_hp_fsm
  import fdc_hp_pkg::*;
#(
  parameter int EXEC_GAP = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nondma_i,
  input  logic       rd_act_i,
  input  logic       rd_end_i,
  input  logic       wr_end_i,
  input  logic       addr_i,
  input  logic [7:0] wdat_i,
  input  logic       settle_done_i,
  output logic       settle_go_o,
  output phase_e     phase_o,
  output logic       rqm_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [7:0] byte_o,
  output logic       irq_o,
  output logic       wr_acc_o,
  output logic       rd_acc_o
);
  localparam int GW = $clog2(EXEC_GAP + 1);

  phase_e          phase_q;
  logic            rqm_q, pend_q, irq_q;
  logic [7:0]      op_q, op_eff;
  logic [CNT_W-1:0] idx_q, idx_nx;
  logic [GW-1:0]   gcnt_q;
  logic            rd_data_end;

  assign rd_data_end = rd_end_i & addr_i;
  assign wr_acc_o    = wr_end_i & addr_i & (phase_q == PH_CMD) & rqm_q;
  assign rd_acc_o    = rd_data_end & (phase_q == PH_RES) & rqm_q;
  assign settle_go_o = wr_acc_o | rd_acc_o;
  assign op_eff      = (idx_q == '0) ? wdat_i : op_q;
  assign idx_nx      = idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      rqm_q   <= 1'b1;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      op_q    <= '0;
      idx_q   <= '0;
      gcnt_q  <= '0;
    end else begin
      if (settle_done_i && phase_q != PH_EXE) rqm_q <= 1'b1;
      unique case (phase_q)
        PH_CMD: if (wr_acc_o) begin
          rqm_q <= 1'b0;
          if (idx_q == '0) op_q <= wdat_i;
          if (idx_nx == cmd_len(op_eff)) begin
            phase_q <= PH_EXE;
            idx_q   <= '0;
            gcnt_q  <= '0;
            pend_q  <= 1'b0;
          end else idx_q <= idx_nx;
        end
        PH_EXE: begin
          if (pend_q) begin
            if (rd_data_end) begin
              pend_q <= 1'b0;
              idx_q  <= idx_nx;
              gcnt_q <= '0;
            end
          end else if (gcnt_q == GW'(EXEC_GAP - 1)) begin
            gcnt_q <= '0;
            if (idx_q == exe_cnt(op_q)) begin
              phase_q <= PH_RES;
              idx_q   <= '0;
              rqm_q   <= 1'b1;
            end else begin
              pend_q <= 1'b1;
              if (nondma_i) irq_q <= 1'b1;
            end
          end else gcnt_q <= gcnt_q + 1'b1;
        end
        PH_RES: if (rd_acc_o) begin
          rqm_q <= 1'b0;
          if (idx_nx == res_cnt(op_q)) begin
            phase_q <= PH_CMD;
            idx_q   <= '0;
          end else idx_q <= idx_nx;
        end
        default: phase_q <= PH_CMD;
      endcase
      // read strobe clears the interrupt, even against a coincident new byte
      if (rd_act_i) irq_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_EXE:  byte_o = op_q + 8'(idx_q) + 8'd1;
      PH_RES:  byte_o = ~op_q + 8'(idx_q);
      default: byte_o = 8'h00;
    endcase
  end

  assign phase_o = phase_q;
  assign rqm_o   = rqm_q;
  assign idx_o   = idx_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/fdc_host_port.sv
module fdc_host_port
  import fdc_hp_pkg::*;
#(
  parameter int SETTLE_CYC = 600,
  parameter int EXEC_GAP   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic       addr_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  input  logic       nondma_i,
  output logic       irq_o
);
  logic       rd_act_w, rd_end_w, wr_end_w, addr_q_w;
  logic [7:0] wdat_w, byte_w, stat_w;
  logic       settle_go_w, settle_done_w, rqm_w, wr_acc_w, rd_acc_w;
  logic [CNT_W-1:0] idx_w;
  phase_e     phase_w;

  fdc_hp_strobe u_strobe (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i,
    .rd_act_o(rd_act_w), .rd_end_o(rd_end_w), .wr_end_o(wr_end_w),
    .addr_o(addr_q_w), .wdat_o(wdat_w)
  );

  fdc_hp_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni, .start_i(settle_go_w), .done_o(settle_done_w)
  );

  fdc_hp_fsm #(.EXEC_GAP(EXEC_GAP)) u_fsm (
    .clk_i, .rst_ni, .nondma_i,
    .rd_act_i(rd_act_w), .rd_end_i(rd_end_w), .wr_end_i(wr_end_w),
    .addr_i(addr_q_w), .wdat_i(wdat_w), .settle_done_i(settle_done_w),
    .settle_go_o(settle_go_w), .phase_o(phase_w), .rqm_o(rqm_w),
    .idx_o(idx_w), .byte_o(byte_w), .irq_o(irq_o),
    .wr_acc_o(wr_acc_w), .rd_acc_o(rd_acc_w)
  );

  assign stat_w = {rqm_w, phase_w == PH_RES, 1'b0, phase_w != PH_CMD, 4'b0000};
  assign data_o = addr_i ? byte_w : stat_w;
endmodule

// File: rtl/fdc_host_port_chk.sv
module fdc_host_port_chk
  import fdc_hp_pkg::*;
#(
  parameter int CNT_WIDTH = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       rd_ni,
  input logic       nondma_i,
  input logic       irq_o,
  input logic       rqm_w,
  input phase_e     phase_w,
  input logic       wr_acc_w,
  input logic       rd_acc_w,
  input logic       wr_end_w,
  input logic [CNT_WIDTH-1:0] idx_w
);
  p_settle_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc_w || rd_acc_w) |=> !rqm_w);

  p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni) |=> !irq_o);

  p_irq_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(nondma_i));

  p_exe_not_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_w == PH_EXE) |-> !rqm_w);

  p_ignored_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_end_w && !rqm_w && phase_w == PH_CMD) |=> $stable(idx_w));
endmodule

bind fdc_host_port fdc_host_port_chk #(.CNT_WIDTH(fdc_hp_pkg::CNT_W)) u_chk (
  .clk_i, .rst_ni, .cs_ni, .rd_ni, .nondma_i, .irq_o,
  .rqm_w, .phase_w, .wr_acc_w, .rd_acc_w, .wr_end_w, .idx_w
);

// File: tb/tb_fdc_host_port.sv
module tb_fdc_host_port;
  localparam int SETTLE = 24;
  localparam int GAP    = 10;
  // {nondma, opcode}
  localparam logic [8:0] VEC [6] = '{9'h000, 9'h117, 9'h12D, 9'h03A, 9'h1F6, 9'h061};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1, addr_i = 1'b0, nondma_i = 1'b0;
  logic [7:0] data_i = '0, data_o;
  logic irq_o;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fdc_host_port #(.SETTLE_CYC(SETTLE), .EXEC_GAP(GAP)) dut (
    .clk_i(clk), .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i,
    .data_o, .nondma_i, .irq_o
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    cs_ni = ~sel; wr_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk);
    cs_ni = 1'b1; wr_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    cs_ni = 1'b0; rd_ni = 1'b0; addr_i = a;
    @(negedge clk);
    d = data_o;
    cs_ni = 1'b1; rd_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic peek(output logic [7:0] s);
    addr_i = 1'b0;
    #1 s = data_o;
  endtask

  task automatic wait_rqm();
    logic [7:0] s;
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      peek(s);
      if (s[7]) return;
    end
    chk(1'b0, "R4 ready timeout", 8'h00, 8'h80);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic nd);
    int n_cmd, n_exe, n_res;
    logic [7:0] s, d;
    bit seen;
    n_cmd = int'(op[1:0]) + 1;
    n_exe = int'(op[5:4]);
    n_res = int'(op[3:2]) + 1;
    nondma_i = nd;
    for (int i = 0; i < n_cmd; i++) begin
      wait_rqm();
      peek(s); chk(s == 8'h80, "R2 command status", s, 8'h80);
      bus_wr(1'b1, (i == 0) ? op : 8'(i * 17 + 3), 1'b1);
    end
    peek(s); chk(s == 8'h10, "R3 execution status", s, 8'h10);
    for (int k = 0; k < n_exe; k++) begin
      if (nd) begin
        seen = 0;
        for (int t = 0; t < GAP * 4 && !seen; t++) begin
          @(negedge clk);
          seen = irq_o;
        end
        chk(seen, "R6 irq per byte", {7'b0, irq_o}, 8'h01);
      end else begin
        repeat (GAP + 3) @(negedge clk);
        chk(irq_o == 1'b0, "R8 no irq in dma", {7'b0, irq_o}, 8'h00);
      end
      bus_rd(1'b1, d);
      chk(d == op + 8'(k) + 8'd1, "R6 exec byte", d, op + 8'(k) + 8'd1);
      if (nd) chk(irq_o == 1'b0, "R7 irq cleared by read", {7'b0, irq_o}, 8'h00);
    end
    wait_rqm();
    peek(s); chk(s == 8'hD0, "R9 result status", s, 8'hD0);
    for (int k = 0; k < n_res; k++) begin
      wait_rqm();
      bus_rd(1'b1, d);
      chk(d == ~op + 8'(k), "R9 result byte", d, ~op + 8'(k));
    end
    peek(s); chk(s == 8'h00, "R10 after last result", s, 8'h00);
    wait_rqm();
    peek(s); chk(s == 8'h80, "R10 back to command", s, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    do_reset();
    peek(s); chk(s == 8'h80, "R1 reset status", s, 8'h80);
    chk(irq_o == 1'b0, "R1 reset irq", {7'b0, irq_o}, 8'h00);

    for (int v = 0; v < 6; v++) run_cmd(VEC[v][7:0], VEC[v][8]);

    // R4 exact settle timing, then R11 early result read
    nondma_i = 1'b0;
    bus_wr(1'b1, 8'h05, 1'b1);
    repeat (SETTLE - 1) @(posedge clk);
    @(negedge clk); peek(s); chk(s[7] == 1'b0, "R4 ready still low", s, 8'h00);
    @(posedge clk);
    @(negedge clk); peek(s); chk(s == 8'h80, "R4 ready restored", s, 8'h80);
    bus_wr(1'b1, 8'h33, 1'b1);
    wait_rqm();
    bus_rd(1'b1, d); chk(d == 8'hFA, "R9 first result", d, 8'hFA);
    bus_rd(1'b1, d);
    wait_rqm();
    bus_rd(1'b1, d); chk(d == 8'hFB, "R11 early read ignored", d, 8'hFB);
    peek(s); chk(s == 8'h00, "R10 idle after results", s, 8'h00);
    wait_rqm();

    // R5 ignored writes
    bus_wr(1'b1, 8'h01, 1'b1);
    bus_wr(1'b1, 8'h55, 1'b1);
    wait_rqm();
    bus_wr(1'b1, 8'h66, 1'b0);
    bus_wr(1'b0, 8'h77, 1'b1);
    wait_rqm();
    peek(s); chk(s == 8'h80, "R5 writes not counted", s, 8'h80);
    bus_wr(1'b1, 8'h22, 1'b1);
    peek(s); chk(s == 8'h10, "R3 second byte ends command", s, 8'h10);
    wait_rqm();
    bus_wr(1'b1, 8'h99, 1'b1);
    peek(s); chk(s == 8'hD0, "R5 write in result ignored", s, 8'hD0);
    bus_rd(1'b1, d); chk(d == 8'hFE, "R9 single result", d, 8'hFE);
    wait_rqm();

    // R7 status read clears irq
    nondma_i = 1'b1;
    bus_wr(1'b1, 8'h10, 1'b1);
    repeat (GAP + 3) @(negedge clk);
    chk(irq_o == 1'b1, "R6 irq raised", {7'b0, irq_o}, 8'h01);
    bus_rd(1'b0, s);
    chk(irq_o == 1'b0, "R7 status read clears irq", {7'b0, irq_o}, 8'h00);
    chk(s == 8'h10, "R2 status in execution", s, 8'h10);
    bus_rd(1'b1, d); chk(d == 8'h11, "R6 exec byte unchecked status", d, 8'h11);

    // R1 reset in mid execution
    do_reset();
    peek(s); chk(s == 8'h80, "R1 reset mid-run", s, 8'h80);
    chk(irq_o == 1'b0, "R1 irq after reset", {7'b0, irq_o}, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule